// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the program counter of a single-cycle processor and chooses its next value at every clock edge. The current counter addresses instruction fetch. The counter plus four is also given out on its own port, so that link instructions can write the return address in the same cycle.

A two-bit source select picks the next counter value from four choices:
- the sequential address;
- a relative branch target, formed by a dedicated adder from the 16-bit immediate;
- an absolute jump target, built from the 26-bit jump field and the upper bits of the current counter;
- a register value, for indirect jumps.

A synchronous reset loads a fixed boot address. A low enable freezes the counter, which lets the processor be single-stepped.

Top module: `pc_sequencer`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc` becomes 0x0040_0000 after that edge.
- R2: When `rst` is low and `en` is low at a rising edge, `pc` keeps its value, whatever `src_sel` and the data inputs are.
- R3: With `rst` low, `en` high and `src_sel` = 0, `pc` becomes the old `pc` + 4 (modulo 2^32) after the edge.
- R4: With `src_sel` = 1, `pc` becomes the old `pc` + 4 + (sign-extended `br_off` × 4). Immediate bit 15 is the sign bit, so negative offsets branch backward.
- R5: With `src_sel` = 2, `pc` becomes {old `pc`[31:28], `jmp_field`[25:0], 2'b00}.
- R6: With `src_sel` = 3, `pc` becomes the value on `reg_target`.
- R7: `pc_next_seq` equals `pc` + 4 (modulo 2^32) in the same cycle, with no clock delay.
- R8: Reset takes priority over enable: `rst` high with `en` low still loads 0x0040_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable; when low, the counter holds |
| src_sel | input | 2 | Next-address source: 0 sequential, 1 branch, 2 jump, 3 register |
| jmp_field | input | 26 | Jump field of the current instruction |
| br_off | input | 16 | Branch immediate of the current instruction (word offset) |
| reg_target | input | 32 | Register value used for an indirect jump |
| pc | output | 32 | Current program counter (fetch address) |
| pc_next_seq | output | 32 | Current program counter plus four |

## Verification
A wrong counter value shows on `pc` one edge after the step that caused it, and on `pc_next_seq` in that same cycle. Every update is checked right after its edge against an address computed in the bench. The jump check depends on the counter's upper nibble, so the jump is taken after an indirect jump has moved the counter into a different 256 MB region. A bad nibble is therefore caught at once. The carry into the top bit is checked by wrapping the counter from 0xFFFF_FFFC to 0.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int          W         = 32,
  parameter int          IW        = 16,
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    src_sel,
  input  logic [W-7:0]  jmp_field,
  input  logic [IW-1:0] br_off,
  input  logic [W-1:0]  reg_target,
  output logic [W-1:0]  pc,
  output logic [W-1:0]  pc_next_seq
);

  localparam int          EXT  = W - IW - 2;
  localparam logic [W-1:0] STEP = W'(4);

  logic [W-1:0] br_disp;
  logic [W-1:0] br_target;
  logic [W-1:0] jmp_target;
  logic [W-1:0] pc_d;

  assign pc_next_seq = pc + STEP;
  assign br_disp     = {{EXT{br_off[IW-1]}}, br_off, 2'b00};
  assign br_target   = pc_next_seq + br_disp;
  assign jmp_target  = {pc[W-1:W-4], jmp_field, 2'b00};

  always_comb begin
    case (src_sel)
      2'd1:    pc_d = br_target;
      2'd2:    pc_d = jmp_target;
      2'd3:    pc_d = reg_target;
      default: pc_d = pc_next_seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     pc <= RESET_VEC[W-1:0];
    else if (en) pc <= pc_d;
  end

  logic primed;
  always_ff @(posedge clk) primed <= 1'b1;

  assert_reset_vec_R1: assert property (@(posedge clk)
    primed && $past(rst) |-> pc == RESET_VEC[W-1:0]);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && !$past(en) |-> $stable(pc));

  assert_seq_R3: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(en) && $past(src_sel) == 2'd0
    |-> pc == $past(pc) + STEP);

  assert_branch_R4: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(en) && $past(src_sel) == 2'd1
    |-> pc == $past(pc) + STEP + W'($signed(br_off_q) * 4));

  assert_jump_R5: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(en) && $past(src_sel) == 2'd2
    |-> pc[W-1:W-4] == $past(pc[W-1:W-4]) && pc[1:0] == 2'b00);

  assert_reg_R6: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && $past(en) && $past(src_sel) == 2'd3
    |-> pc == $past(reg_target));

  assert_link_R7: assert property (@(posedge clk)
    primed |-> pc_next_seq - pc == STEP);

  assert_rst_over_en_R8: assert property (@(posedge clk)
    primed && $past(rst) && !$past(en) |-> pc == RESET_VEC[W-1:0]);

  logic [IW-1:0] br_off_q;
  always_ff @(posedge clk) br_off_q <= br_off;

endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [25:0] jmp_field = '0;
  logic [15:0] br_off = '0;
  logic [31:0] reg_target = '0;
  logic [31:0] pc, pc_next_seq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .en(en), .src_sel(src_sel), .jmp_field(jmp_field),
    .br_off(br_off), .reg_target(reg_target), .pc(pc), .pc_next_seq(pc_next_seq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic [1:0] s,
                      input logic [25:0] j, input logic [15:0] b, input logic [31:0] rv);
    @(negedge clk);
    rst = r; en = e; src_sel = s; jmp_field = j; br_off = b; reg_target = rv;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    step(1, 1, 2'd3, 26'h3FFFFFF, 16'hFFFF, 32'h1234_5678);
    model = 32'h0040_0000;
    check("R1", pc, model);
    check("R7", pc_next_seq, 32'h0040_0004);
  endtask

  task automatic t_seq;
    for (int k = 0; k < 3; k++) begin
      step(0, 1, 2'd0, 26'h155, 16'h7FFF, 32'hFFFF_FFFF);
      model = model + 4;
      check("R3", pc, model);
      check("R7", pc_next_seq, model + 4);
    end
  endtask

  task automatic t_branch;
    step(0, 1, 2'd1, '0, 16'd3, '0);
    model = model + 4 + 12;
    check("R4 forward", pc, model);
    step(0, 1, 2'd1, '0, 16'hFFFF, '0);
    check("R4 minus-one", pc, model);
    step(0, 1, 2'd1, '0, 16'h8000, '0);
    model = model + 4 - 32'h0002_0000;
    check("R4 most-negative", pc, model);
  endtask

  task automatic t_reg_and_jump;
    step(0, 1, 2'd3, 26'h3FFFFFF, 16'h0004, 32'hDEAD_BEE0);
    model = 32'hDEAD_BEE0;
    check("R6", pc, model);
    step(0, 1, 2'd2, 26'h2A5_5AA1, 16'h0004, 32'h0);
    model = {4'hD, 26'h2A5_5AA1, 2'b00};
    check("R5", pc, model);
  endtask

  task automatic t_hold;
    for (int s = 0; s < 4; s++) begin
      step(0, 0, 2'(s), 26'h111, 16'h0100, 32'h0BAD_0000);
      check("R2", pc, model);
    end
  endtask

  task automatic t_wrap;
    step(0, 1, 2'd3, '0, '0, 32'hFFFF_FFFC);
    check("R7 top", pc_next_seq, 32'h0000_0000);
    step(0, 1, 2'd0, '0, '0, '0);
    check("R3 wrap", pc, 32'h0000_0000);
  endtask

  task automatic t_reset_priority;
    step(1, 0, 2'd3, '0, '0, 32'h5555_5554);
    model = 32'h0040_0000;
    check("R8", pc, model);
    step(0, 0, 2'd0, '0, '0, '0);
    check("R2 after reset", pc, model);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_branch();
    t_reg_and_jump();
    t_hold();
    t_wrap();
    t_reset_priority();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule